// File: doc/BRIEF.md
# Gated Timer with Synchronized Gate

This block is a 16-bit up-counter driven by a prescaled timer clock. Counting can be opened and closed by a gate. The gate is either an external digital pin or the digital output of an analog comparator. A small configuration register chooses the gate source. It also decides whether the comparator level is used directly or is first captured on the falling edge of the prescaled timer clock. Because the counter steps on the rising edge of that same clock, a change of the comparator can never fall inside an increment.

All logic runs on one system clock. The timer's input clock runs at half the system clock. The prescaler divides it by 1, 2, 4 or 8 and produces one rising-edge strobe and one falling-edge strobe per prescaled period. A system that measures how long an analog level stays high sets the comparator as the gate source and turns synchronization on. It then reads the count.

Top module: `gtmr_top`

## Requirements
- R1: After reset the count is 0, the overflow flag is 0 and the configuration register reads 0x02 (source-select 1, sync 0).
- R2: A configuration write stores data bit 1 as source-select and data bit 0 as sync. Reads return {6'b0, source-select, sync}. Data bits 7 to 2 are ignored and always read as 0.
- R3: The prescale field values 0, 1, 2 and 3 give N = 1, 2, 4 and 8. One prescaled period lasts 2*N system cycles. Starting from a disabled timer, K enabled cycles with the gate open add floor(K / (2*N)) to the count.
- R4: While the timer enable is low the count holds and the prescaler phase returns to zero.
- R5: With gate enable low, the counter counts on every prescaled rising edge while the timer is enabled, whatever the pin and comparator do.
- R6: With gate enable high and source-select 1, the counter advances only while the gate pin is high. The pin passes through a two-flop synchronizer first.
- R7: With gate enable high, source-select 0 and sync 0, the comparator level at a rising strobe decides whether that strobe counts.
- R8: With gate enable high, source-select 0 and sync 1, the comparator is captured at each falling strobe (prescaler phase N-1). A rising strobe uses the value captured at the falling strobe before it, so a comparator change between the falling and rising strobes takes effect only one period later.
- R9: The count wraps from 0xFFFF to 0x0000, and the overflow flag is high for exactly one cycle, in the cycle after the wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_en | input | 1 | Timer enable |
| gate_en | input | 1 | Gate enable |
| presc_sel | input | 2 | Prescale select (divide by 1, 2, 4, 8) |
| gate_pin | input | 1 | External gate pin, asynchronous |
| cmp_out | input | 1 | Comparator output level |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data |
| count | output | 16 | Current count |
| ovf | output | 1 | One-cycle overflow pulse |

## Verification
A count step caused by a rising strobe at system edge t appears at the count port after edge t. The captured comparator value from a falling strobe is used at the rising strobe N cycles later. A configuration write appears on the read port after the edge that samples it. The pin needs two extra edges through its synchronizer. The bench drives every input on the falling clock edge and samples one half-cycle after the last rising edge of each step. Each scenario starts from a disabled timer, so the prescaler phase is known to be zero. The expected counts are derived from the number of rising strobes, floor(K/(2N)). In the synchronization test, the comparator is changed right after a falling strobe and the count is checked after the next rising strobe.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;
    localparam int PH_W = 4;

    typedef struct packed {
        logic [PH_W-1:0] phase;
    } presc_state_t;

    typedef struct packed {
        logic pin_s1;
        logic pin_s2;
        logic cmp_hold;
    } gate_state_t;
endpackage

// File: rtl/gtmr_presc.sv
module gtmr_presc
    import gtmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] div_sel,
    output logic       rise,
    output logic       fall
);
    presc_state_t st_d, st_q;
    logic [PH_W-1:0] half, last;

    always_comb begin
        half = PH_W'(1) << div_sel;
        last = PH_W'((half << 1) - 1);
        rise = en && (st_q.phase == last);
        fall = en && (st_q.phase == PH_W'(half - 1));
        st_d = st_q;
        if (!en || rise) st_d.phase = '0;
        else             st_d.phase = st_q.phase + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4
    phase_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (st_q.phase == '0));
    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise && fall));
endmodule

// File: rtl/gtmr_gate.sv
module gtmr_gate
    import gtmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fall,
    input  logic gate_en,
    input  logic use_pin,
    input  logic sync_en,
    input  logic pin,
    input  logic cmp,
    output logic gate_open
);
    gate_state_t st_d, st_q;
    logic cmp_level;

    always_comb begin
        st_d        = st_q;
        st_d.pin_s1 = pin;
        st_d.pin_s2 = st_q.pin_s1;
        if (fall) st_d.cmp_hold = cmp;
        cmp_level = sync_en ? st_q.cmp_hold : cmp;
        gate_open = !gate_en || (use_pin ? st_q.pin_s2 : cmp_level);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fall |=> $stable(st_q.cmp_hold));
    // R6
    pin_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.pin_s2 == $past(st_q.pin_s1)));
endmodule

// File: rtl/gtmr_top.sv
module gtmr_top #(
    parameter int CNT_W = 16,
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmr_en,
    input  logic             gate_en,
    input  logic [1:0]       presc_sel,
    input  logic             gate_pin,
    input  logic             cmp_out,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             src_pin;
        logic             sync_on;
        logic             ovf;
    } top_state_t;

    top_state_t st_d, st_q;
    logic rise, fall, gate_open;

    gtmr_presc u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (tmr_en),
        .div_sel (presc_sel),
        .rise    (rise),
        .fall    (fall)
    );

    gtmr_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall      (fall),
        .gate_en   (gate_en),
        .use_pin   (st_q.src_pin),
        .sync_en   (st_q.sync_on),
        .pin       (gate_pin),
        .cmp       (cmp_out),
        .gate_open (gate_open)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ovf = 1'b0;
        if (cfg_we) begin
            st_d.src_pin = cfg_wdata[1];
            st_d.sync_on = cfg_wdata[0];
        end
        if (rise && gate_open) begin
            st_d.cnt = st_q.cnt + 1'b1;
            st_d.ovf = (st_q.cnt == CNT_MAX);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.src_pin <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_rdata = {{(CFG_W-2){1'b0}}, st_q.src_pin, st_q.sync_on};
    assign count     = st_q.cnt;
    assign ovf       = st_q.ovf;

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (count == '0));
    // R3
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count != $past(count)) |-> (count == $past(count) + 1'b1));
    // R4
    hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_en |=> $stable(count));
    // R2
    cfg_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_rdata == {{(CFG_W-2){1'b0}}, $past(cfg_wdata[1:0])}));
endmodule

// File: tb/tb_gtmr_top.sv
`timescale 1ns/1ps
module tb_gtmr_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tmr_en = 1'b0, gate_en = 1'b0;
    logic [1:0]  presc_sel = 2'd0;
    logic        gate_pin = 1'b0, cmp_out = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic [15:0] count;
    logic        ovf;

    int checks = 0, errors = 0, ovf_seen = 0;

    always #10 clk = ~clk;

    gtmr_top dut (.*);

    always @(negedge clk) if (ovf) ovf_seen++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run(input int k);
        repeat (k) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_cfg(input logic [7:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        run(1);
        cfg_we = 1'b0;
    endtask

    // timer on for k cycles, then off; returns count delta
    task automatic burst(input int k, output int delta);
        int base;
        base = count;
        tmr_en = 1'b1;
        run(k);
        tmr_en = 1'b0;
        delta = int'(count) - base;
        run(1);
    endtask

    task automatic t_reset();
        chk("R1 count", count, 0);
        chk("R1 ovf", ovf, 0);
        chk("R1 cfg", cfg_rdata, 8'h02);
    endtask

    task automatic t_cfg();
        wr_cfg(8'hFF); chk("R2 write ff", cfg_rdata, 8'h03);
        wr_cfg(8'hFC); chk("R2 write fc", cfg_rdata, 8'h00);
        wr_cfg(8'h01); chk("R2 write 01", cfg_rdata, 8'h01);
    endtask

    task automatic t_presc();
        int d;
        gate_en = 1'b0;
        presc_sel = 2'd0; burst(40, d); chk("R3 div1", d, 20);
        presc_sel = 2'd1; burst(40, d); chk("R3 div2", d, 10);
        presc_sel = 2'd2; burst(40, d); chk("R3 div4", d, 5);
        presc_sel = 2'd3; burst(48, d); chk("R3 div8", d, 3);
        presc_sel = 2'd3; burst(15, d); chk("R4 phase cleared", d, 0);
        presc_sel = 2'd0;
    endtask

    task automatic t_hold();
        int base;
        base = count;
        tmr_en = 1'b0;
        run(30);
        chk("R4 hold", count, base);
    endtask

    task automatic t_free();
        int d;
        gate_en = 1'b0; gate_pin = 1'b0; cmp_out = 1'b0;
        wr_cfg(8'h02);
        burst(20, d); chk("R5 free run", d, 10);
    endtask

    task automatic t_pin();
        int d;
        gate_en = 1'b1; wr_cfg(8'h02);
        gate_pin = 1'b0; cmp_out = 1'b1; run(4);
        burst(20, d); chk("R6 pin low", d, 0);
        gate_pin = 1'b1; cmp_out = 1'b0; run(4);
        burst(20, d); chk("R6 pin high", d, 10);
        gate_pin = 1'b0; run(4);
    endtask

    task automatic t_cmp_async();
        int d;
        gate_en = 1'b1; wr_cfg(8'h00);
        gate_pin = 1'b1; cmp_out = 1'b0; run(4);
        burst(20, d); chk("R7 cmp low", d, 0);
        cmp_out = 1'b1;
        burst(20, d); chk("R7 cmp high", d, 10);
    endtask

    task automatic t_cmp_sync(input logic syn);
        int base;
        gate_en = 1'b1; presc_sel = 2'd3;
        wr_cfg(syn ? 8'h01 : 8'h00);
        cmp_out = 1'b0;
        base = count;
        tmr_en = 1'b1;
        run(24);                 // rise at edge 16, fall at edge 24
        cmp_out = 1'b1;
        run(8);                  // rise at edge 32
        chk(syn ? "R8 late change" : "R7 late change", int'(count) - base, syn ? 0 : 1);
        run(16);                 // fall at 40 captures 1, rise at 48
        chk(syn ? "R8 captured" : "R7 next", int'(count) - base, syn ? 1 : 2);
        tmr_en = 1'b0; run(1);
        presc_sel = 2'd0;
    endtask

    task automatic t_wrap();
        int need;
        gate_en = 1'b0; presc_sel = 2'd0;
        need = 65536 - int'(count);
        ovf_seen = 0;
        tmr_en = 1'b1;
        run(2 * need);
        chk("R9 wrap", count, 0);
        chk("R9 ovf now", ovf, 1);
        tmr_en = 1'b0;
        run(3);
        chk("R9 one pulse", ovf_seen, 1);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        run(3);
        rst_n = 1'b1;
        run(1);
        t_reset();
        t_cfg();
        t_presc();
        t_hold();
        t_free();
        t_pin();
        t_cmp_async();
        t_cmp_sync(1'b1);
        t_cmp_sync(1'b0);
        t_wrap();
        finish_run();
    end
endmodule